// File: doc/BRIEF.md
# Timer and External-Interrupt Control Register

This block holds an 8-bit control and status byte for a small microcontroller core, along with the logic that sets and clears its bits. Two 16-bit timers send it a one-cycle pulse each time they wrap from FFFFh to 0000h. The block latches each wrap as a request flag and gives each timer a run-enable output. Two active-low external interrupt pins pass through synchronizers. On each pin the block detects either a falling edge or a sustained low level, chosen by a mode bit in the byte, and raises a request flag.

The interrupt controller reads the four request flags. When it vectors to one of those sources, it sends a one-hot acknowledge pulse that clears the matching flag. Software reaches the byte in two ways: a whole-byte write at the byte address, or a single-bit write at bit address base+n, which changes only bit n. Bit positions are fixed: bit 7 is timer-1 wrap, 6 is timer-1 run, 5 is timer-0 wrap, 4 is timer-0 run, 3 is pin-1 request, 2 is pin-1 mode, 1 is pin-0 request and 0 is pin-0 mode.

Top module: `tmr_xint_ctrl_reg`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset is released, all eight bits read 0.
- R2: The run bits (6 and 4) and the mode bits (2 and 0) change only by a software write, one cycle after that write. `runEn[1]` mirrors bit 6 and `runEn[0]` mirrors bit 4.
- R3: A pulse on `tmrWrap[c]` sets bit 5+2c, which `tmrReq[c]` mirrors, one cycle later.
- R4: A pulse on `ackTmr[c]` clears bit 5+2c one cycle later. If a wrap pulse for the same timer arrives in the same cycle, the bit is set instead.
- R5: A software write to a timer flag loads the written value. For that flag the priority is: wrap first, then acknowledge, then software write, then hold.
- R6: When mode bit 2c is 1 (edge mode), a falling edge on `xPinN[c]` sets bit 1+2c, which `extReq[c]` mirrors, three cycles after the pin changes. A pin that stays low or rises does not set the flag again.
- R7: In edge mode, an `ackExt[c]` pulse or a software write of 0 clears bit 1+2c. A detected edge in the same cycle wins, and the flag ends up set.
- R8: When mode bit 2c is 0 (level mode), bit 1+2c equals the inverse of `xPinN[c]` as it was three cycles earlier. `ackExt[c]` and software writes to that bit have no effect.
- R9: A bit write with `bitAddr` from BASE_ADDR to BASE_ADDR+7 (88h to 8Fh by default) changes only bit `bitAddr[2:0]`. A bit write at any other address changes nothing.
- R10: A byte write with `byteAddr` equal to BASE_ADDR loads all eight bits, subject to R4, R5, R7 and R8. A byte write at any other address changes nothing. When a byte write and a bit write land in the same cycle, the bit write's value wins on its bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tmrWrap | input | 2 | One-cycle wrap pulses from timers 1 and 0 |
| ackTmr | input | 2 | Vector acknowledge for the timer flags, one-hot |
| ackExt | input | 2 | Vector acknowledge for the pin flags, one-hot |
| xPinN | input | 2 | Asynchronous active-low external interrupt pins |
| byteWe | input | 1 | Byte write strobe |
| byteAddr | input | 8 | Byte write address |
| byteWdata | input | 8 | Byte write data |
| bitWe | input | 1 | Single-bit write strobe |
| bitAddr | input | 8 | Bit write address |
| bitWdata | input | 1 | Bit write data |
| regOut | output | 8 | Current register contents |
| runEn | output | 2 | Run enables to timers 1 and 0 |
| tmrReq | output | 2 | Timer wrap requests to the interrupt controller |
| extReq | output | 2 | External pin requests to the interrupt controller |

## Verification
Writes, wrap pulses and acknowledges all appear one clock edge after they are driven. A pin change passes through two synchronizer flops and the flag register, so it appears three edges later. The bench drives every input on a falling clock edge and samples on a later falling edge, counting exactly one or three rising edges in between. For pin events it also checks the edge just before the result is due, to confirm the latency is exact. Byte-write sweeps wait one extra idle edge before checking, and the expected value folds in that edge, during which level-mode flags follow the pins.

// File: rtl/tmr_xint_pkg.sv
package tmr_xint_pkg;
  localparam int NCH = 2;

  typedef struct packed {
    logic [7:0]     wrMask;
    logic [7:0]     wrVal;
    logic [NCH-1:0] tmrSet;
    logic [NCH-1:0] tmrClr;
    logic [NCH-1:0] extEdge;
    logic [NCH-1:0] extClr;
    logic [NCH-1:0] extLow;
  } ctlStb_t;

  function automatic int ovfPos(input int ch);
    return 5 + 2 * ch;
  endfunction
  function automatic int runPos(input int ch);
    return 4 + 2 * ch;
  endfunction
  function automatic int xfPos(input int ch);
    return 1 + 2 * ch;
  endfunction
  function automatic int xmPos(input int ch);
    return 2 * ch;
  endfunction
endpackage

// File: rtl/txc_sync.sv
module txc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shReg <= '1;
    else       shReg <= {shReg[STAGES-2:0], din};
  end

  assign dout = shReg[STAGES-1];
endmodule

// File: rtl/txc_ctl.sv
module txc_ctl
  import tmr_xint_pkg::*;
#(
  parameter logic [7:0] BASE_ADDR   = 8'h88,
  parameter int         SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [NCH-1:0] tmrWrap,
  input  logic [NCH-1:0] ackTmr,
  input  logic [NCH-1:0] ackExt,
  input  logic [NCH-1:0] xPinN,
  input  logic           byteWe,
  input  logic [7:0]     byteAddr,
  input  logic [7:0]     byteWdata,
  input  logic           bitWe,
  input  logic [7:0]     bitAddr,
  input  logic           bitWdata,
  output ctlStb_t        stb
);
  logic [NCH-1:0] syncN;
  logic [NCH-1:0] prevN;
  logic           byteHit;
  logic           bitHit;
  logic [2:0]     bitIdx;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_pin
    txc_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk (clk),
      .rstN(rstN),
      .din (xPinN[ch]),
      .dout(syncN[ch])
    );
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) prevN[ch] <= 1'b1;
      else       prevN[ch] <= syncN[ch];
    end
  end

  assign byteHit = byteWe && (byteAddr == BASE_ADDR);
  assign bitHit  = bitWe && (bitAddr[7:3] == BASE_ADDR[7:3]);
  assign bitIdx  = bitAddr[2:0];

  always_comb begin
    stb.wrMask = byteHit ? 8'hFF : 8'h00;
    stb.wrVal  = byteHit ? byteWdata : 8'h00;
    if (bitHit) begin
      stb.wrMask[bitIdx] = 1'b1;
      stb.wrVal[bitIdx]  = bitWdata;
    end
    stb.tmrSet  = tmrWrap;
    stb.tmrClr  = ackTmr;
    stb.extClr  = ackExt;
    stb.extEdge = prevN & ~syncN;
    stb.extLow  = ~syncN;
  end
endmodule

// File: rtl/txc_dp.sv
module txc_dp
  import tmr_xint_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctlStb_t    stb,
  output logic [7:0] regQ
);
  logic [7:0] regD;

  always_comb begin
    regD = regQ;
    for (int ch = 0; ch < NCH; ch++) begin
      // timer wrap flag: set > acknowledge > write > hold
      if (stb.tmrSet[ch])            regD[ovfPos(ch)] = 1'b1;
      else if (stb.tmrClr[ch])       regD[ovfPos(ch)] = 1'b0;
      else if (stb.wrMask[ovfPos(ch)]) regD[ovfPos(ch)] = stb.wrVal[ovfPos(ch)];
      // plain configuration bits
      if (stb.wrMask[runPos(ch)]) regD[runPos(ch)] = stb.wrVal[runPos(ch)];
      if (stb.wrMask[xmPos(ch)])  regD[xmPos(ch)]  = stb.wrVal[xmPos(ch)];
      // pin flag: level mode tracks the pin, edge mode latches
      if (!regQ[xmPos(ch)])          regD[xfPos(ch)] = stb.extLow[ch];
      else if (stb.extEdge[ch])      regD[xfPos(ch)] = 1'b1;
      else if (stb.extClr[ch])       regD[xfPos(ch)] = 1'b0;
      else if (stb.wrMask[xfPos(ch)]) regD[xfPos(ch)] = stb.wrVal[xfPos(ch)];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regQ <= 8'h00;
    else       regQ <= regD;
  end
endmodule

// File: rtl/tmr_xint_ctrl_reg.sv
module tmr_xint_ctrl_reg
  import tmr_xint_pkg::*;
#(
  parameter logic [7:0] BASE_ADDR   = 8'h88,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] tmrWrap,
  input  logic [1:0] ackTmr,
  input  logic [1:0] ackExt,
  input  logic [1:0] xPinN,
  input  logic       byteWe,
  input  logic [7:0] byteAddr,
  input  logic [7:0] byteWdata,
  input  logic       bitWe,
  input  logic [7:0] bitAddr,
  input  logic       bitWdata,
  output logic [7:0] regOut,
  output logic [1:0] runEn,
  output logic [1:0] tmrReq,
  output logic [1:0] extReq
);
  ctlStb_t    stb;
  logic [7:0] regQ;

  txc_ctl #(.BASE_ADDR(BASE_ADDR), .SYNC_STAGES(SYNC_STAGES)) ctl_i (
    .clk      (clk),
    .rstN     (rstN),
    .tmrWrap  (tmrWrap),
    .ackTmr   (ackTmr),
    .ackExt   (ackExt),
    .xPinN    (xPinN),
    .byteWe   (byteWe),
    .byteAddr (byteAddr),
    .byteWdata(byteWdata),
    .bitWe    (bitWe),
    .bitAddr  (bitAddr),
    .bitWdata (bitWdata),
    .stb      (stb)
  );

  txc_dp dp_i (
    .clk (clk),
    .rstN(rstN),
    .stb (stb),
    .regQ(regQ)
  );

  assign regOut = regQ;
  for (genvar ch = 0; ch < NCH; ch++) begin : g_out
    assign runEn[ch]  = regQ[runPos(ch)];
    assign tmrReq[ch] = regQ[ovfPos(ch)];
    assign extReq[ch] = regQ[xfPos(ch)];
  end
endmodule

// File: rtl/txc_chk.sv
module txc_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] tmrWrap,
  input logic [1:0] ackTmr,
  input logic       byteWe,
  input logic       bitWe,
  input logic [7:0] regOut
);
  // R1
  rst_clear_chk: assert property (@(posedge clk) !rstN |=> regOut == 8'h00);

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!byteWe && !bitWe) |=> $stable({regOut[6], regOut[4], regOut[2], regOut[0]}));

  // R3
  tmr0_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    tmrWrap[0] |=> regOut[5]);

  // R3
  tmr1_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    tmrWrap[1] |=> regOut[7]);

  // R3
  tmr1_norise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tmrWrap[1] && !byteWe && !bitWe) |=> !$rose(regOut[7]));

  // R4
  tmr0_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackTmr[0] && !tmrWrap[0]) |=> !regOut[5]);
endmodule

bind tmr_xint_ctrl_reg txc_chk chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .tmrWrap(tmrWrap),
  .ackTmr (ackTmr),
  .byteWe (byteWe),
  .bitWe  (bitWe),
  .regOut (regOut)
);

// File: tb/tmr_xint_ctrl_reg_tb_top.sv
module tmr_xint_ctrl_reg_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] tmrWrap = '0, ackTmr = '0, ackExt = '0, xPinN = 2'b11;
  logic       byteWe = 1'b0, bitWe = 1'b0, bitWdata = 1'b0;
  logic [7:0] byteAddr = '0, byteWdata = '0, bitAddr = '0;
  logic [7:0] regOut;
  logic [1:0] runEn, tmrReq, extReq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] model;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tmr_xint_ctrl_reg dut_i (
    .clk(clk), .rstN(rstN), .tmrWrap(tmrWrap), .ackTmr(ackTmr), .ackExt(ackExt),
    .xPinN(xPinN), .byteWe(byteWe), .byteAddr(byteAddr), .byteWdata(byteWdata),
    .bitWe(bitWe), .bitAddr(bitAddr), .bitWdata(bitWdata),
    .regOut(regOut), .runEn(runEn), .tmrReq(tmrReq), .extReq(extReq)
  );

  // expected contents after one write edge, pins idle high
  function automatic logic [7:0] expWrite(logic [7:0] old, logic [7:0] mask, logic [7:0] val);
    logic [7:0] n = (old & ~mask) | (val & mask);
    if (!old[0]) n[1] = 1'b0;
    if (!old[2]) n[3] = 1'b0;
    return n;
  endfunction

  function automatic logic [7:0] expIdle(logic [7:0] m);
    logic [7:0] n = m;
    if (!m[0]) n[1] = 1'b0;
    if (!m[2]) n[3] = 1'b0;
    return n;
  endfunction

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chkByte(string req, logic [7:0] exp);
    checks++;
    if (regOut !== exp || runEn !== {exp[6], exp[4]} || tmrReq !== {exp[7], exp[5]} ||
        extReq !== {exp[3], exp[1]}) begin
      errors++;
      $display("FAIL %s: regOut=%h runEn=%b tmrReq=%b extReq=%b expected byte %h",
               req, regOut, runEn, tmrReq, extReq, exp);
    end
  endtask

  task automatic chkBit(string req, int idx, logic exp);
    checks++;
    if (regOut[idx] !== exp) begin
      errors++;
      $display("FAIL %s: bit %0d actual %b expected %b", req, idx, regOut[idx], exp);
    end
  endtask

  task automatic byteWr(logic [7:0] addr, logic [7:0] data);
    byteWe = 1'b1; byteAddr = addr; byteWdata = data;
    cyc();
    byteWe = 1'b0;
  endtask

  task automatic bitWr(logic [7:0] addr, logic data);
    bitWe = 1'b1; bitAddr = addr; bitWdata = data;
    cyc();
    bitWe = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    chkByte("R1 during reset", 8'h00);
    rstN = 1'b1;
    cyc();
    chkByte("R1 after reset", 8'h00);
    model = 8'h00;

    // R10 / R2: byte sweep over every value
    for (int v = 0; v < 256; v++) begin
      byteWr(8'h88, 8'(v));
      cyc();
      model = expIdle(expWrite(model, 8'hFF, 8'(v)));
      chkByte("R10 R2 byte sweep", model);
    end

    // R9: every bit address with both values
    for (int a = 0; a < 8; a++) begin
      for (int d = 0; d < 2; d++) begin
        bitWr(8'h88 + 8'(a), d[0]);
        model = expWrite(model, 8'(1) << a, {8{d[0]}});
        chkByte("R9 bit write", model);
        cyc();
        model = expIdle(model);
      end
    end
    bitWr(8'h87, 1'b1);
    chkByte("R9 address below range ignored", model);
    bitWr(8'h90, ~model[0]);
    chkByte("R9 address above range ignored", model);

    // R4 / R5: priority sweep of wrap, acknowledge, software write
    for (int ch = 0; ch < 2; ch++) begin
      for (int init = 0; init < 2; init++) begin
        for (int wr = 0; wr < 2; wr++) begin
          for (int ak = 0; ak < 2; ak++) begin
            for (int ws = 0; ws < 3; ws++) begin
              logic e;
              bitWr(8'h8D + 8'(2 * ch), init[0]);
              tmrWrap[ch] = wr[0];
              ackTmr[ch] = ak[0];
              if (ws != 0) begin
                bitWe = 1'b1; bitAddr = 8'h8D + 8'(2 * ch); bitWdata = (ws == 2);
              end
              cyc();
              tmrWrap = '0; ackTmr = '0; bitWe = 1'b0;
              e = wr[0] ? 1'b1 : ak[0] ? 1'b0 : (ws != 0) ? (ws == 2) : init[0];
              chkBit("R4 R5 R3 timer flag priority", 5 + 2 * ch, e);
              checks++;
              if (tmrReq[ch] !== e) begin
                errors++;
                $display("FAIL R3 tmrReq[%0d]: actual %b expected %b", ch, tmrReq[ch], e);
              end
            end
          end
        end
      end
    end

    // R6 / R7: edge mode on both pins
    byteWr(8'h88, 8'h05);
    cyc();
    chkByte("R10 edge setup", 8'h05);
    xPinN[0] = 1'b0;
    cyc(); cyc();
    chkBit("R6 no flag before third edge", 1, 1'b0);
    cyc();
    chkByte("R6 falling edge sets pin0 flag", 8'h07);
    ackExt[0] = 1'b1;
    cyc();
    ackExt[0] = 1'b0;
    chkBit("R7 acknowledge clears edge flag", 1, 1'b0);
    repeat (4) cyc();
    chkBit("R6 held low does not set again", 1, 1'b0);
    xPinN[0] = 1'b1;
    repeat (4) cyc();
    chkBit("R6 rising edge does not set", 1, 1'b0);
    xPinN[0] = 1'b0;
    cyc(); cyc();
    ackExt[0] = 1'b1;
    cyc();
    ackExt[0] = 1'b0;
    chkBit("R7 edge wins over acknowledge", 1, 1'b1);
    bitWr(8'h89, 1'b0);
    chkBit("R7 software clear", 1, 1'b0);
    xPinN[0] = 1'b1;
    xPinN[1] = 1'b0;
    cyc(); cyc(); cyc();
    chkByte("R6 pin1 falling edge", 8'h0D);
    xPinN[1] = 1'b1;
    bitWr(8'h8B, 1'b0);
    repeat (3) cyc();
    chkByte("R7 pin1 cleared and pins idle", 8'h05);

    // R8: level mode on pin 1
    byteWr(8'h88, 8'h00);
    chkByte("R8 level setup", 8'h00);
    xPinN[1] = 1'b0;
    cyc(); cyc();
    chkBit("R8 level not yet visible", 3, 1'b0);
    cyc();
    chkBit("R8 low level requests", 3, 1'b1);
    ackExt[1] = 1'b1;
    cyc();
    ackExt[1] = 1'b0;
    chkBit("R8 acknowledge ignored in level mode", 3, 1'b1);
    bitWr(8'h8B, 1'b0);
    chkBit("R8 software write ignored in level mode", 3, 1'b1);
    xPinN[1] = 1'b1;
    cyc(); cyc();
    chkBit("R8 flag still follows older sample", 3, 1'b1);
    cyc();
    chkByte("R8 released pin drops request", 8'h00);

    // R10: byte and bit write together, and a foreign byte address
    byteWr(8'h88, 8'h05);
    cyc();
    byteWe = 1'b1; byteAddr = 8'h88; byteWdata = 8'hFF;
    bitWe = 1'b1; bitAddr = 8'h8E; bitWdata = 1'b0;
    cyc();
    byteWe = 1'b0; bitWe = 1'b0;
    chkByte("R10 bit write wins on its bit", 8'hBF);
    byteWr(8'h89, 8'h00);
    chkByte("R10 other byte address ignored", 8'hBF);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule